// File: doc/BRIEF.md
# Multicycle Processor Phase Sequencer with Shared Bus Control

This block steps a simple 32-bit processor through its instruction phases and drives the one memory bus that serves instruction fetch, data loads and data stores. It is a Moore machine. The phases are fetch, decode, execute, load, store and writeback. Each phase raises its own enable output, and that output depends only on the current phase. The datapath around the block uses these enables to clock its own registers. The decoder, register file, ALU and program counter update logic sit outside the block.

The bus uses a valid/ready handshake. A transfer completes on a clock edge where valid and ready are both high. On that edge the block captures the bus read data into a register. The bus address comes from one of two sources:

- During fetch, it is the program counter, which the block receives on an input.
- In every other phase, it is an ALU result that the block latched at the end of the execute phase.

The execute phase branches three ways, using flags from the decoded instruction. The priority order is load, then store, then a write to a destination register.

Top module: `mc_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the machine enters fetch (`phase_en` = 6'b000001) and the read-data register clears to zero.
- R2: In fetch, the machine stays in fetch while `ready` is low and moves to decode on an edge where `ready` is high.
- R3: Decode always moves to execute after one cycle, whatever the value of `ready`.
- R4: From execute, the machine goes to load if `ins_load` is high; otherwise to store if `ins_store` is high; otherwise to writeback if `ins_has_dest` is high; otherwise back to fetch.
- R5: Load waits for `ready` and then moves to writeback. Store waits for `ready` and then moves to fetch.
- R6: Writeback always returns to fetch after one cycle, whatever the value of `ready`.
- R7: `phase_en` is one-hot at all times. The bit order is 0 fetch, 1 decode, 2 execute, 3 load, 4 store, 5 writeback.
- R8: `bus_valid` is high exactly in the fetch, load and store phases.
- R9: In fetch, `addr_sel` is 0 and `bus_addr` equals `pc_in`. In every other phase, `addr_sel` is 1 and `bus_addr` equals the value of `alu_in` sampled on the last edge at which the machine was in execute.
- R10: `rdata_q` loads `bus_rdata` on every edge where `bus_valid` and `ready` are both high. It holds its value on every other edge, including edges where `ready` is high while `bus_valid` is low.
- R11: In load and store, `bus_addr` holds its value while the machine waits for `ready`, even if `alu_in` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ready | input | 1 | Responder has completed or accepts the transfer |
| ins_load | input | 1 | Current instruction is a memory load |
| ins_store | input | 1 | Current instruction is a memory store |
| ins_has_dest | input | 1 | Current instruction writes a destination register |
| pc_in | input | AW | Program counter value from the datapath |
| alu_in | input | AW | ALU result from the datapath, latched at the end of execute |
| bus_rdata | input | DW | Read data from the bus |
| phase_en | output | 6 | One-hot phase enables (bit 0 fetch … bit 5 writeback) |
| bus_valid | output | 1 | Transfer request |
| addr_sel | output | 1 | Address source: 0 program counter, 1 latched ALU result |
| bus_addr | output | AW | Bus address |
| rdata_q | output | DW | Read data captured when a transfer completes |

## Verification
The bound checker checks the following on every cycle:

- the one-hot enables;
- the match between valid and the bus phases;
- the address-select polarity;
- each state transition that does not depend on the flag priority;
- the capture and hold rule of the read-data register;
- address stability during a stalled load or store.

The bench's scenarios cover the behaviours that no single-cycle property can show:

- the priority of the three execute branches when several flags are high;
- reset taking effect in the middle of a transfer;
- that the latched ALU value is the one present on the execute edge rather than a later value;
- that a stray `ready` outside a bus phase leaves the read-data register untouched.

// File: rtl/mc_seq_pkg.sv
// Shared definitions for the multicycle sequencer.
// Assumes the phase codes run from 0 upward, so that code N maps to enable bit N.
package mc_seq_pkg;
    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_EXEC   = 3'd2,
        PH_LOAD   = 3'd3,
        PH_STORE  = 3'd4,
        PH_WBACK  = 3'd5
    } phase_t;

    localparam int unsigned PH_COUNT = 6;
endpackage

// File: rtl/seq_fsm.sv
// Phase state register and next-phase logic.
// Assumes the instruction flags are valid while the machine is in execute.
module seq_fsm
    import mc_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ready,
    input  logic   ins_load,
    input  logic   ins_store,
    input  logic   ins_has_dest,
    output phase_t state
);
    phase_t state_nx;

    // Next-phase selection; execute uses load > store > dest priority.
    always_comb begin
        state_nx = state;
        unique case (state)
            PH_FETCH:  if (ready) state_nx = PH_DECODE;
            PH_DECODE: state_nx = PH_EXEC;
            PH_EXEC: begin
                if (ins_load)          state_nx = PH_LOAD;
                else if (ins_store)    state_nx = PH_STORE;
                else if (ins_has_dest) state_nx = PH_WBACK;
                else                   state_nx = PH_FETCH;
            end
            PH_LOAD:   if (ready) state_nx = PH_WBACK;
            PH_STORE:  if (ready) state_nx = PH_FETCH;
            PH_WBACK:  state_nx = PH_FETCH;
            default:   state_nx = PH_FETCH;
        endcase
    end

    // Phase register with synchronous active-low reset to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PH_FETCH;
        else        state <= state_nx;
    end
endmodule

// File: rtl/seq_phase_dec.sv
// Decodes the phase code into one enable bit per phase (Moore outputs).
// Assumes enable bit N corresponds to phase code N.
module seq_phase_dec
    import mc_seq_pkg::*;
#(
    parameter int unsigned NPH = PH_COUNT
) (
    input  phase_t         state,
    output logic [NPH-1:0] en
);
    for (genvar g = 0; g < NPH; g++) begin : g_en
        localparam logic [2:0] CODE = 3'(g);
        // One comparator per phase.
        assign en[g] = (state == phase_t'(CODE));
    end
endmodule

// File: rtl/seq_bus_ctl.sv
// Bus-side control: valid, address source selection, ALU result latch
// and read-data capture. Assumes the phase enables are one-hot.
module seq_bus_ctl #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_en,
    input  logic          exec_en,
    input  logic          load_en,
    input  logic          store_en,
    input  logic          ready,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] alu_in,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_valid,
    output logic          addr_sel,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] rdata_q
);
    logic [AW-1:0] alu_q;
    logic          xfer_done;

    // Request the bus in the three transfer phases.
    always_comb begin
        bus_valid = fetch_en | load_en | store_en;
        xfer_done = bus_valid & ready;
        addr_sel  = ~fetch_en;
        bus_addr  = addr_sel ? alu_q : pc_in;
    end

    // Latch the ALU result at the end of execute only.
    always_ff @(posedge clk) begin
        if (!rst_n)       alu_q <= '0;
        else if (exec_en) alu_q <= alu_in;
    end

    // Capture read data when a transfer completes.
    always_ff @(posedge clk) begin
        if (!rst_n)         rdata_q <= '0;
        else if (xfer_done) rdata_q <= bus_rdata;
    end
endmodule

// File: rtl/mc_sequencer.sv
// Top of the multicycle sequencer: phase machine, enable decoder and bus control.
// Assumes pc_in stays stable while a fetch waits for ready.
module mc_sequencer
    import mc_seq_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ready,
    input  logic                ins_load,
    input  logic                ins_store,
    input  logic                ins_has_dest,
    input  logic [AW-1:0]       pc_in,
    input  logic [AW-1:0]       alu_in,
    input  logic [DW-1:0]       bus_rdata,
    output logic [PH_COUNT-1:0] phase_en,
    output logic                bus_valid,
    output logic                addr_sel,
    output logic [AW-1:0]       bus_addr,
    output logic [DW-1:0]       rdata_q
);
    phase_t state;

    seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ready        (ready),
        .ins_load     (ins_load),
        .ins_store    (ins_store),
        .ins_has_dest (ins_has_dest),
        .state        (state)
    );

    seq_phase_dec #(.NPH(PH_COUNT)) u_dec (
        .state (state),
        .en    (phase_en)
    );

    seq_bus_ctl #(.AW(AW), .DW(DW)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .fetch_en  (phase_en[PH_FETCH]),
        .exec_en   (phase_en[PH_EXEC]),
        .load_en   (phase_en[PH_LOAD]),
        .store_en  (phase_en[PH_STORE]),
        .ready     (ready),
        .pc_in     (pc_in),
        .alu_in    (alu_in),
        .bus_rdata (bus_rdata),
        .bus_valid (bus_valid),
        .addr_sel  (addr_sel),
        .bus_addr  (bus_addr),
        .rdata_q   (rdata_q)
    );
endmodule

// File: rtl/mc_sequencer_chk.sv
// Property checker for mc_sequencer, attached through bind.
// Assumes the phase_en bit order 0 fetch, 1 decode, 2 execute, 3 load, 4 store, 5 writeback.
module mc_sequencer_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ready,
    input logic          ins_load,
    input logic [5:0]    phase_en,
    input logic          bus_valid,
    input logic          addr_sel,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_rdata,
    input logic [DW-1:0] rdata_q
);
    AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(phase_en) == 1); // R7
    AST_VALID_PHASES: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid == (phase_en[0] | phase_en[3] | phase_en[4])); // R8
    AST_ADDR_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        addr_sel == !phase_en[0]); // R9
    AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        phase_en[0] && !ready |=> phase_en[0]); // R2
    AST_FETCH_GO: assert property (@(posedge clk) disable iff (!rst_n)
        phase_en[0] && ready |=> phase_en[1]); // R2
    AST_DECODE_GO: assert property (@(posedge clk) disable iff (!rst_n)
        phase_en[1] |=> phase_en[2]); // R3
    AST_EXEC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        phase_en[2] && ins_load |=> phase_en[3]); // R4
    AST_LOAD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_en[3] && ready |=> phase_en[5]); // R5
    AST_STORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_en[4] && ready |=> phase_en[0]); // R5
    AST_WBACK_GO: assert property (@(posedge clk) disable iff (!rst_n)
        phase_en[5] |=> phase_en[0]); // R6
    AST_RDATA_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && ready |=> rdata_q == $past(bus_rdata)); // R10
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && ready) |=> $stable(rdata_q)); // R10
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !ready && !phase_en[0] |=> $stable(bus_addr)); // R11
endmodule

bind mc_sequencer mc_sequencer_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .ins_load  (ins_load),
    .phase_en  (phase_en),
    .bus_valid (bus_valid),
    .addr_sel  (addr_sel),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .rdata_q   (rdata_q)
);

// File: tb/sim_mc_sequencer.sv
module sim_mc_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int WATCHDOG_CYCLES = 5000;

    // Phase codes as one-hot enables: F D E L S W.
    localparam logic [5:0] F = 6'b000001, D = 6'b000010, E = 6'b000100,
                           L = 6'b001000, S = 6'b010000, W = 6'b100000;

    // Entry: {rst_n, ready, ld, st, dest, expected phase after the edge}.
    localparam int NVEC = 26;
    localparam logic [10:0] VEC [NVEC] = '{
        {5'b00000, F},  // R1 reset
        {5'b10000, F},  // R2 hold
        {5'b11000, D},  // R2 go
        {5'b10000, E},  // R3
        {5'b10111, L},  // R4 load wins
        {5'b10000, L},  // R5 wait
        {5'b11000, W},  // R5 done
        {5'b10000, F},  // R6
        {5'b11000, D},
        {5'b10000, E},
        {5'b10011, S},  // R4 store over dest
        {5'b10000, S},  // R5 wait
        {5'b11000, F},  // R5 done
        {5'b11000, D},
        {5'b11000, E},  // R3 ignores ready
        {5'b11001, W},  // R4 dest only
        {5'b11000, F},  // R6 ignores ready
        {5'b11000, D},
        {5'b10000, E},
        {5'b11000, F},  // R4 no flags
        {5'b10000, F},
        {5'b01000, F},  // R1 reset in fetch
        {5'b11000, D},
        {5'b10000, E},
        {5'b10100, L},
        {5'b00000, F}   // R1 reset mid-load
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ready = 1'b0;
    logic          ins_load = 1'b0;
    logic          ins_store = 1'b0;
    logic          ins_has_dest = 1'b0;
    logic [AW-1:0] pc_in = '0;
    logic [AW-1:0] alu_in = '0;
    logic [DW-1:0] bus_rdata = '0;
    logic [5:0]    phase_en;
    logic          bus_valid;
    logic          addr_sel;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] rdata_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    mc_sequencer #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .ready(ready), .ins_load(ins_load),
        .ins_store(ins_store), .ins_has_dest(ins_has_dest), .pc_in(pc_in),
        .alu_in(alu_in), .bus_rdata(bus_rdata), .phase_en(phase_en),
        .bus_valid(bus_valid), .addr_sel(addr_sel), .bus_addr(bus_addr),
        .rdata_q(rdata_q)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at the falling edge, then sample 1 time unit after the rising edge.
    task automatic step(input logic rst, input logic rdy, input logic ld,
                        input logic st, input logic dst, input logic [DW-1:0] rd);
        @(negedge clk);
        rst_n = rst; ready = rdy; ins_load = ld; ins_store = st;
        ins_has_dest = dst; bus_rdata = rd;
        @(posedge clk);
        #1;
    endtask

    function automatic string req_of(input logic rst, input logic [5:0] prev);
        if (!rst) return "R1";
        case (prev)
            F: return "R2";
            D: return "R3";
            E: return "R4";
            W: return "R6";
            default: return "R5";
        endcase
    endfunction

    initial begin
        logic [5:0] prev;
        prev = F;
        // Table walk: phase sequence, valid and address select.
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], 32'h0);
            check(req_of(VEC[i][10], prev), {26'd0, phase_en}, {26'd0, VEC[i][5:0]});
            check("R7", {31'd0, ($countones(phase_en) == 1)}, 32'd1);
            check("R8", {31'd0, bus_valid}, {31'd0, (VEC[i][5:0] == F) || (VEC[i][5:0] == L) || (VEC[i][5:0] == S)});
            check("R9", {31'd0, addr_sel}, {31'd0, VEC[i][5:0] != F});
            prev = VEC[i][5:0];
        end

        // Directed: reset clears the capture register.
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        check("R1", rdata_q, 32'h0);
        pc_in = 32'h0000_0100;
        #1;
        check("R9", bus_addr, 32'h0000_0100);
        // Fetch completes: data captured.
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'hDEAD_BEEF);
        check("R10", rdata_q, 32'hDEAD_BEEF);
        // Ready in decode (valid low) must not capture.
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h1111_1111);
        check("R10", rdata_q, 32'hDEAD_BEEF);
        // Execute edge latches alu_in.
        alu_in = 32'h0000_2004;
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
        check("R9", bus_addr, 32'h0000_2004);
        check("R9", {31'd0, addr_sel}, 32'd1);
        // Stalled load: address holds, no capture.
        alu_in = 32'h0000_3333;
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h5555_5555);
        check("R11", bus_addr, 32'h0000_2004);
        check("R10", rdata_q, 32'hDEAD_BEEF);
        // Load completes.
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'hCAFE_0001);
        check("R10", rdata_q, 32'hCAFE_0001);
        check("R5", {26'd0, phase_en}, {26'd0, W});
        check("R9", bus_addr, 32'h0000_2004);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule